// File: doc/BRIEF.md
# SHA-256 Compression Engine with Early Candidate Rejection

This block tests one candidate for a brute-force preimage search. It takes a 512-bit message block, the 256-bit chaining value that the block is compressed into, and the 256-bit digest being searched for. It then runs the SHA-256 compression function at one round per clock. The 16-word message schedule is produced on the fly from a sliding window, so the expanded schedule is never stored.

After the 61st of the 64 rounds, two of the eight final digest words are already fixed. The new `e` value only moves through `f` and `g` into `h`, and the new `a` value only moves through `b` and `c` into `d`. Neither value is changed again before the final addition. The engine compares these two values with the target word minus the chaining word. If either differs, it stops, reports a miss and skips the last three rounds and the final addition. A candidate that survives the check runs to the end, and its full digest is compared with the target.

A search controller places a job with a start/ready handshake. It waits for a single-cycle `done` pulse, then reads `match` and `early_abort`.

Top module: `sha_search_core`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `ready` is 1 and `done`, `match` and `early_abort` are 0.
- R2: A job is accepted on a clock edge where `start` and `ready` are both 1. `ready` stays 0 from that edge through the cycle in which `done` is high, and it returns to 1 on the following cycle. `start` has no effect while `ready` is 0.
- R3: The block, chaining value and target are captured at the accepting edge. Changes on those inputs during a job do not affect its result.
- R4: For a job that runs all 64 rounds, `digest` equals the SHA-256 compression of the block into the chaining value. The schedule is the standard σ0/σ1 recurrence, the round constants are the standard ones, and all additions are modulo 2^32. Word 0 is bits 255:224 of `digest`, `chain` and `target`. Message word 0 is bits 511:480 of `block`.
- R5: After the 61st round, the job is rejected if the working variable `a` differs from target word 3 minus chain word 3, or if `e` differs from target word 7 minus chain word 7. In either case the job is not completed.
- R6: A rejected job raises `done` and `early_abort` together, with `match` = 0, in the cycle that starts 61 clock edges after the accepting edge.
- R7: A job that is not rejected raises `done` in the cycle that starts 65 clock edges after the accepting edge, with `early_abort` = 0. `match` is 1 exactly when all eight digest words equal the target words. `match` is 0 whenever `done` is 0.
- R8: `done` is high for exactly one cycle per accepted job.
- R9: The block holding the 3-byte message "abc" (standard padding), compressed into the standard initial hash value, gives digest ba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad and reports a match against that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a job; taken when `ready` is 1 |
| block | input | 512 | Candidate message block, word 0 in the top bits |
| chain | input | 256 | Chaining value, word 0 in the top bits |
| target | input | 256 | Digest searched for, word 0 in the top bits |
| ready | output | 1 | Engine idle and able to accept a job |
| done | output | 1 | One-cycle pulse marking the end of a job |
| match | output | 1 | Valid with `done`: the full digest equals the target |
| early_abort | output | 1 | Valid with `done`: the job was rejected after round 61 |
| digest | output | 256 | Computed digest; valid with `done` when `early_abort` is 0 |

## Verification
The assertions measure latency from the accepting edge. They therefore assume that `start` is only acted on while `ready` is high, and that reset is not pulsed in the middle of a job. The stimulus waits on `ready` before each request and asserts reset only once, at the start. One job keeps `start` high for the whole run and changes every data input after acceptance. This checks that busy-time requests and input changes are ignored. Reject cases are made by altering target word 3 or word 7. Full-length misses are made by altering any other word, so both exit paths are exercised together with random blocks.

// File: rtl/sha_search_pkg.sv
package sha_search_pkg;

    localparam int WORD_W   = 32;
    localparam int N_VARS   = 8;
    localparam int WIN_LEN  = 16;
    localparam int N_ROUNDS = 64;
    localparam int RND_W    = $clog2(N_ROUNDS);
    localparam int BLK_W    = WIN_LEN * WORD_W;
    localparam int HASH_W   = N_VARS * WORD_W;
    // zero-based index of the round after which the early check is made
    localparam int CHK_RND  = N_ROUNDS - 4;
    // words fixed after the check round: d-slot and h-slot
    localparam int A_SLOT   = 3;
    localparam int E_SLOT   = 7;

    typedef logic [WORD_W-1:0]              word_t;
    typedef logic [N_VARS-1:0][WORD_W-1:0]  vars_t;
    typedef logic [WIN_LEN-1:0][WORD_W-1:0] win_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e           phase;
        logic [RND_W-1:0] rnd;
        vars_t            v;
        win_t             win;
        vars_t            chn;
        vars_t            tgt;
        vars_t            dig;
        logic             done;
        logic             hit;
        logic             abrt;
    } core_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t round_k(input logic [RND_W-1:0] i);
        case (i)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction

endpackage

// File: rtl/sha_search_sched.sv
module sha_search_sched
    import sha_search_pkg::*;
(
    input  win_t  win_q,
    output word_t w_now,
    output win_t  win_d
);
    word_t lo_sig;
    word_t hi_sig;
    word_t w_new;

    always_comb begin
        lo_sig = rotr(win_q[1], 7) ^ rotr(win_q[1], 18) ^ (win_q[1] >> 3);
        hi_sig = rotr(win_q[14], 17) ^ rotr(win_q[14], 19) ^ (win_q[14] >> 10);
        w_new  = hi_sig + win_q[9] + lo_sig + win_q[0];
        w_now  = win_q[0];
        win_d  = {w_new, win_q[WIN_LEN-1:1]};
    end
endmodule

// File: rtl/sha_search_round.sv
module sha_search_round
    import sha_search_pkg::*;
(
    input  vars_t v_q,
    input  word_t k_i,
    input  word_t w_i,
    output vars_t v_d
);
    word_t big_s1, choose, sum1, big_s0, major, sum2;

    always_comb begin
        big_s1 = rotr(v_q[4], 6) ^ rotr(v_q[4], 11) ^ rotr(v_q[4], 25);
        choose = (v_q[4] & v_q[5]) ^ (~v_q[4] & v_q[6]);
        sum1   = v_q[7] + big_s1 + choose + k_i + w_i;
        big_s0 = rotr(v_q[0], 2) ^ rotr(v_q[0], 13) ^ rotr(v_q[0], 22);
        major  = (v_q[0] & v_q[1]) ^ (v_q[0] & v_q[2]) ^ (v_q[1] & v_q[2]);
        sum2   = big_s0 + major;
        for (int j = 0; j < N_VARS; j++) begin
            v_d[j] = (j == 0) ? v_q[0] : v_q[j-1];
        end
        v_d[0] = sum1 + sum2;
        v_d[4] = v_q[3] + sum1;
    end
endmodule

// File: rtl/sha_search_core.sv
module sha_search_core
    import sha_search_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  block,
    input  logic [HASH_W-1:0] chain,
    input  logic [HASH_W-1:0] target,
    output logic              ready,
    output logic              done,
    output logic              match,
    output logic              early_abort,
    output logic [HASH_W-1:0] digest
);
    core_t core_q, core_d;
    vars_t rnd_v;
    win_t  win_nx;
    word_t w_cur;
    logic  keep_a, keep_e;
    logic  all_eq;
    vars_t sum_v;

    sha_search_sched u_sched (
        .win_q (core_q.win),
        .w_now (w_cur),
        .win_d (win_nx)
    );

    sha_search_round u_round (
        .v_q (core_q.v),
        .k_i (round_k(core_q.rnd)),
        .w_i (w_cur),
        .v_d (rnd_v)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        core_d.hit  = 1'b0;
        core_d.abrt = 1'b0;
        keep_a = (rnd_v[0] == core_q.tgt[A_SLOT] - core_q.chn[A_SLOT]);
        keep_e = (rnd_v[4] == core_q.tgt[E_SLOT] - core_q.chn[E_SLOT]);
        all_eq = 1'b1;
        for (int j = 0; j < N_VARS; j++) begin
            sum_v[j] = core_q.chn[j] + core_q.v[j];
            if (sum_v[j] != core_q.tgt[j]) all_eq = 1'b0;
        end
        case (core_q.phase)
            ST_IDLE: begin
                if (start) begin
                    core_d.phase = ST_RUN;
                    core_d.rnd   = '0;
                    for (int j = 0; j < WIN_LEN; j++)
                        core_d.win[j] = block[BLK_W-1-WORD_W*j -: WORD_W];
                    for (int j = 0; j < N_VARS; j++) begin
                        core_d.chn[j] = chain[HASH_W-1-WORD_W*j -: WORD_W];
                        core_d.tgt[j] = target[HASH_W-1-WORD_W*j -: WORD_W];
                        core_d.v[j]   = chain[HASH_W-1-WORD_W*j -: WORD_W];
                    end
                end
            end
            ST_RUN: begin
                core_d.v   = rnd_v;
                core_d.win = win_nx;
                core_d.rnd = core_q.rnd + 1'b1;
                if (core_q.rnd == RND_W'(CHK_RND) && !(keep_a && keep_e)) begin
                    core_d.phase = ST_DONE;
                    core_d.done  = 1'b1;
                    core_d.abrt  = 1'b1;
                end else if (core_q.rnd == RND_W'(N_ROUNDS - 1)) begin
                    core_d.phase = ST_FIN;
                end
            end
            ST_FIN: begin
                core_d.dig   = sum_v;
                core_d.hit   = all_eq;
                core_d.done  = 1'b1;
                core_d.phase = ST_DONE;
            end
            default: begin
                core_d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        ready       = (core_q.phase == ST_IDLE);
        done        = core_q.done;
        match       = core_q.hit;
        early_abort = core_q.abrt;
        for (int j = 0; j < N_VARS; j++)
            digest[HASH_W-1-WORD_W*j -: WORD_W] = core_q.dig[j];
    end
endmodule

// File: rtl/sha_search_chk.sv
module sha_search_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ready,
    input logic done,
    input logic match,
    input logic early_abort
);
    logic [6:0] since_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_go <= '0;
        else if (start && ready)    since_go <= '0;
        else if (since_go != 7'h7f) since_go <= since_go + 7'd1;
    end

    p_idle_state_r1: assert property (@(posedge clk) !rst_n |-> !done && !match && !early_abort);
    p_busy_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ready);
    p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> ready);
    p_abort_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && early_abort) |-> since_go == 7'd61);
    p_abort_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        early_abort |-> done && !match);
    p_full_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !early_abort) |-> since_go == 7'd65);
    p_hit_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n) match |-> done);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

bind sha_search_core sha_search_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ready       (ready),
    .done        (done),
    .match       (match),
    .early_abort (early_abort)
);

// File: tb/tb_sha_search_core.sv
module tb_sha_search_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] block = '0;
    logic [255:0] chain = '0;
    logic [255:0] target = '0;
    logic         ready, done, match, early_abort;
    logic [255:0] digest;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [255:0] IV  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [255:0] ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;

    typedef struct {
        int unsigned  due;
        logic         abrt;
        logic         hit;
        logic [255:0] dig;
        string        tag;
    } exp_t;
    exp_t sb[$];

    sha_search_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .block(block), .chain(chain),
        .target(target), .ready(ready), .done(done), .match(match),
        .early_abort(early_abort), .digest(digest)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic void model(input logic [511:0] blk, input logic [255:0] ch,
                                  output logic [255:0] dig, output logic [31:0] a61,
                                  output logic [31:0] e61);
        logic [31:0] w [64];
        logic [31:0] s [8];
        logic [31:0] t1, t2;
        a61 = '0; e61 = '0;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 64; i++)
            w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
                 + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
        for (int j = 0; j < 8; j++) s[j] = ch[255-32*j -: 32];
        for (int i = 0; i < 64; i++) begin
            t1 = s[7] + (rr(s[4],6) ^ rr(s[4],11) ^ rr(s[4],25))
               + ((s[4] & s[5]) ^ (~s[4] & s[6])) + sha_search_pkg::round_k(6'(i)) + w[i];
            t2 = (rr(s[0],2) ^ rr(s[0],13) ^ rr(s[0],22))
               + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
            s[7] = s[6]; s[6] = s[5]; s[5] = s[4]; s[4] = s[3] + t1;
            s[3] = s[2]; s[2] = s[1]; s[1] = s[0]; s[0] = t1 + t2;
            if (i == 60) begin a61 = s[0]; e61 = s[4]; end
        end
        for (int j = 0; j < 8; j++) dig[255-32*j -: 32] = ch[255-32*j -: 32] + s[j];
    endfunction

    // driver: places one job and pushes the expected outcome
    task automatic run_job(input logic [511:0] blk, input logic [255:0] ch,
                           input logic [255:0] tg, input bit hold, input string tag);
        exp_t e;
        logic [255:0] dg;
        logic [31:0] a61, e61;
        model(blk, ch, dg, a61, e61);
        e.abrt = (a61 != tg[159:128] - ch[159:128]) || (e61 != tg[31:0] - ch[31:0]);
        e.hit  = !e.abrt && (dg == tg);
        e.dig  = dg;
        e.tag  = tag;
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1; block = blk; chain = ch; target = tg;
        @(negedge clk);
        e.due = cyc + (e.abrt ? 61 : 65);
        sb.push_back(e);
        check(ready == 1'b0, "R2", {tag, " ready low after accept"}, 256'(ready), 256'(0));
        if (hold) begin
            block = ~blk; chain = ~ch; target = ~tg;   // R3: changes mid-job
            while (!done) @(negedge clk);
            start = 1'b0;
        end else begin
            start = 1'b0;
            while (!done) @(negedge clk);
        end
        @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every done pulse
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done)
                check(ready && !done, "R8", "ready back and done gone after pulse",
                      256'({ready, done}), 256'(2'b10));
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "done with no job pending", 256'(1), 256'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, e.abrt ? "R6" : "R7", {e.tag, " done timing"},
                          256'(cyc), 256'(e.due));
                    check(early_abort == e.abrt, "R5", {e.tag, " early_abort"},
                          256'(early_abort), 256'(e.abrt));
                    check(match == e.hit, "R7", {e.tag, " match"}, 256'(match), 256'(e.hit));
                    check(!ready, "R2", {e.tag, " ready low with done"}, 256'(ready), 256'(0));
                    if (!e.abrt)
                        check(digest == e.dig, "R4", {e.tag, " digest"}, digest, e.dig);
                end
            end
            prev_done <= done;
        end
    end

    function automatic logic [511:0] rnd_blk();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
        return b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 256'(cyc), 256'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [511:0] abc_blk;
        logic [255:0] dg;
        logic [31:0]  a61, e61;
        abc_blk = '0;
        abc_blk[511:480] = 32'h61626380;
        abc_blk[31:0]    = 32'h00000018;

        repeat (3) @(negedge clk);
        check({ready, done, match, early_abort} == 4'b1000, "R1", "in reset",
              256'({ready, done, match, early_abort}), 256'(4'b1000));
        rst_n = 1'b1;
        @(negedge clk);
        check({ready, done, match, early_abort} == 4'b1000, "R1", "after reset",
              256'({ready, done, match, early_abort}), 256'(4'b1000));

        model(abc_blk, IV, dg, a61, e61);
        check(dg == ABC, "R9", "bench model on known vector", dg, ABC);
        run_job(abc_blk, IV, ABC, 1'b0, "R9 known vector");
        run_job(abc_blk, IV, ABC ^ {32'h1, 224'h0}, 1'b0, "R7 word0 off");
        run_job(abc_blk, IV, ABC ^ 256'h1, 1'b0, "R5 word7 off");
        run_job(abc_blk, IV, ABC ^ {96'h0, 32'h80000000, 128'h0}, 1'b0, "R5 word3 off");
        run_job(abc_blk, IV, ABC, 1'b1, "R3 held start");
        run_job(abc_blk, IV, ABC ^ {32'h0, 32'h10, 192'h0}, 1'b1, "R2 held start miss");

        for (int n = 0; n < 12; n++) begin
            logic [511:0] b;
            logic [255:0] c;
            b = rnd_blk();
            c = rnd_blk()[255:0];
            model(b, c, dg, a61, e61);
            run_job(b, c, rnd_blk()[255:0], 1'b0, "R6 random target");
            run_job(b, c, dg, 1'b0, "R4 random exact");
            run_job(b, c, dg ^ {64'h0, 32'h4, 160'h0}, n[0], "R7 random word2 off");
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R8", "scoreboard drained", 256'(sb.size()), 256'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule